// File: doc/BRIEF.md
# Four-Channel Phase-Angle Dimmer Trigger Generator

This block drives the gate triggers of four phase-controlled mains loads. It locks onto a zero-cross pulse and splits the low part of each zero-cross cycle (one mains half-cycle) into a fixed number of ticks. Each channel holds a countdown that is loaded from its delay when the zero-cross pulse rises. The countdown runs during the following half-cycle. When it expires, that channel's active-low trigger is pulled low and stays low until the next rise of the zero-cross input. A small firing delay therefore gives a bright load, and a long one gives a dim load.

The delay comes from an 8-bit level for each channel. Two curves are available. In linear mode the delay is the bit-inverse of the level. In switch mode the output is either fully on or fully off. The tick period tunes itself. At the end of each half-cycle the block looks at how many ticks fitted into it and moves the tick timer's reload value one step up or down, so that the tick count stays near the full range. A watchdog forces every trigger inactive and raises a mains-fail flag when zero-cross pulses stop arriving.

Top module: `phase_dimmer`

## Requirements
- R1: After reset every trigger output is high (inactive) and the mains-fail flag is low.
- R2: The zero-cross input passes through two synchronising flops. Its falling edge starts the tick timer, which then produces one tick every (2^TICK_W - reload) * CLK_DIV clocks. The reload value starts at RELOAD_INIT.
- R3: A channel loaded with delay d (1..255) drives its trigger low on the d-th tick after the zero-cross falling edge.
- R4: Once low, a trigger stays low until the zero-cross rising edge. That edge returns all four triggers high and stops the tick timer.
- R5: Channel delays are sampled only at the zero-cross rising edge. A level or mode change during a half-cycle has no effect on that half-cycle's firing.
- R6: In linear mode (mode_switch = 0) the delay is the bitwise inverse of the level. The one exception is level 255, whose delay is 1.
- R7: In switch mode (mode_switch = 1) the delay is 1 when bit 7 of the level is set and 254 when it is clear.
- R8: At a rising edge that ends a timed half-cycle, a tick count from 128 to 254 inclusive raises the reload value by one.
- R9: A tick count below 2 lowers the reload value by one. Any other count, including 2..127 and 255, leaves it unchanged.
- R10: No reload change happens at a rising edge that was not preceded by a running tick timer, which is the case after reset or after a mains failure.
- R11: If no zero-cross falling edge arrives within WD_DIV * 2^WD_W clocks, the mains-fail flag rises, all triggers go high and the tick timer stops. The flag stays high until the next falling edge.
- R12: A zero-cross falling edge clears the mains-fail flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_in | input | 1 | Zero-cross pulse, low during the timed half-cycle |
| mode_switch | input | 1 | 0 = linear curve, 1 = on/off switch curve |
| levels_i | input | CHANNELS*8 | Packed channel levels, channel c in bits [8c+7:8c] |
| trig_n_o | output | CHANNELS | Active-low trigger per channel |
| mains_fail_o | output | 1 | High when zero-cross pulses have stopped |

## Verification
The assertions assume that the zero-cross input holds each level for more than three clocks, so that every edge is seen once by the synchroniser. They also assume that a full zero-cross period is shorter than the watchdog window, except when the bench deliberately stops the pulses. The stimulus drives zero-cross phases hundreds of clocks long, with gaps well inside the shortened watchdog window. The only exception is a single deliberately stretched phase used to trip the mains failure.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int LEVEL_W = 8;
  localparam int POS_HALF = 2 ** (LEVEL_W - 1);
  localparam int POS_MAX = 2 ** LEVEL_W - 1;

  typedef logic [LEVEL_W-1:0] level_t;
  typedef enum logic [1:0] {STEP_HOLD, STEP_UP, STEP_DOWN} step_e;

  // Level to firing delay for the two curves.
  function automatic level_t level_to_delay(input level_t lvl, input logic sw);
    level_t d;
    if (sw) d = lvl[LEVEL_W-1] ? level_t'(1) : level_t'(POS_MAX - 1);
    else if (lvl == level_t'(POS_MAX)) d = level_t'(1);
    else d = ~lvl;
    return d;
  endfunction

  // Reload adjustment chosen from the ticks counted in one half-cycle.
  function automatic step_e adapt_step(input level_t count);
    step_e s;
    if (count >= level_t'(POS_HALF) && count != level_t'(POS_MAX)) s = STEP_UP;
    else if (count < level_t'(2)) s = STEP_DOWN;
    else s = STEP_HOLD;
    return s;
  endfunction
endpackage

// File: rtl/pd_tick_gen.sv
module pd_tick_gen #(
  parameter int CLK_DIV     = 4,
  parameter int TICK_W      = 8,
  parameter int RELOAD_INIT = 61
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic adapt_i,
  output logic tick_o,
  output logic running_o
);
  localparam int PRE_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic              running_q;
  logic [TICK_W-1:0] timer_q;
  logic [TICK_W-1:0] reload_q;
  pd_pkg::level_t    pos_q;
  pd_pkg::step_e     step;
  logic              strobe;

  generate
    if (CLK_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else if (!running_q || pre_q == PRE_W'(CLK_DIV - 1)) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
      end
      assign strobe = running_q && (pre_q == PRE_W'(CLK_DIV - 1));
    end else begin : g_nopre
      assign strobe = running_q;
    end
  endgenerate

  assign step   = pd_pkg::adapt_step(pos_q);
  assign tick_o = strobe && (timer_q == '1);
  assign running_o = running_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      timer_q   <= '0;
      pos_q     <= '0;
      reload_q  <= TICK_W'(RELOAD_INIT);
    end else if (stop_i) begin
      running_q <= 1'b0;
      if (adapt_i && running_q) begin
        case (step)
          pd_pkg::STEP_UP:   reload_q <= reload_q + 1'b1;
          pd_pkg::STEP_DOWN: reload_q <= reload_q - 1'b1;
          default:           reload_q <= reload_q;
        endcase
      end
    end else if (start_i) begin
      running_q <= 1'b1;
      timer_q   <= reload_q;
      pos_q     <= '0;
    end else if (strobe) begin
      if (timer_q == '1) begin
        timer_q <= reload_q;
        pos_q   <= pos_q + 1'b1;
      end else begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  // R8 R9 R10: the period is only retuned between half-cycles
  assert_reload_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q != $past(reload_q)) |-> ($past(adapt_i) && $past(running_q)));
endmodule

// File: rtl/pd_mains_watchdog.sv
module pd_mains_watchdog #(
  parameter int WD_DIV = 32,
  parameter int WD_W   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic expire_o,
  output logic fail_o
);
  localparam int PRE_W = (WD_DIV > 1) ? $clog2(WD_DIV) : 1;

  logic [WD_W-1:0] cnt_q;
  logic            fail_q;
  logic            strobe;

  generate
    if (WD_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else if (clear_i || pre_q == PRE_W'(WD_DIV - 1)) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
      end
      assign strobe = !clear_i && (pre_q == PRE_W'(WD_DIV - 1));
    end else begin : g_nopre
      assign strobe = !clear_i;
    end
  endgenerate

  assign expire_o = strobe && (cnt_q == '1);
  assign fail_o   = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      if (strobe) cnt_q <= cnt_q + 1'b1;
      if (expire_o) fail_q <= 1'b1;
    end
  end

  // R11: the flag only rises on an expiry
  assert_fail_from_expiry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(expire_o));
endmodule

// File: rtl/pd_channel.sv
module pd_channel (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           release_i,
  input  logic           tick_i,
  input  pd_pkg::level_t delay_i,
  output logic           trig_n_o
);
  pd_pkg::level_t cnt_q;
  logic           trig_q;

  assign trig_n_o = trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trig_q <= 1'b1;
    end else begin
      if (load_i) cnt_q <= delay_i;
      else if (tick_i) cnt_q <= cnt_q - 1'b1;
      if (release_i) trig_q <= 1'b1;
      else if (tick_i && cnt_q == pd_pkg::level_t'(1)) trig_q <= 1'b0;
    end
  end

  // R3: a trigger only fires on a tick
  assert_fire_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_q) |-> $past(tick_i));
  // R5: the countdown only moves by load or tick
  assert_count_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ($past(load_i) || $past(tick_i)));
endmodule

// File: rtl/phase_dimmer.sv
module phase_dimmer #(
  parameter int CHANNELS    = 4,
  parameter int CLK_DIV     = 4,
  parameter int TICK_W      = 8,
  parameter int RELOAD_INIT = 61,
  parameter int WD_DIV      = 32,
  parameter int WD_W        = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 zc_in,
  input  logic                                 mode_switch,
  input  logic [CHANNELS*pd_pkg::LEVEL_W-1:0]  levels_i,
  output logic [CHANNELS-1:0]                  trig_n_o,
  output logic                                 mains_fail_o
);
  localparam int LW = pd_pkg::LEVEL_W;

  logic zc_meta_q, zc_sync_q, zc_prev_q;
  logic fall_ev, rise_ev;
  logic fail_ev, mains_fail;
  logic tick, running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_meta_q <= 1'b0;
      zc_sync_q <= 1'b0;
      zc_prev_q <= 1'b0;
    end else begin
      zc_meta_q <= zc_in;
      zc_sync_q <= zc_meta_q;
      zc_prev_q <= zc_sync_q;
    end
  end

  assign fall_ev = zc_prev_q && !zc_sync_q;
  assign rise_ev = !zc_prev_q && zc_sync_q;

  pd_mains_watchdog #(.WD_DIV(WD_DIV), .WD_W(WD_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .clear_i(fall_ev),
    .expire_o(fail_ev), .fail_o(mains_fail)
  );

  pd_tick_gen #(.CLK_DIV(CLK_DIV), .TICK_W(TICK_W), .RELOAD_INIT(RELOAD_INIT)) u_tick (
    .clk(clk), .rst_n(rst_n), .start_i(fall_ev), .stop_i(rise_ev || fail_ev),
    .adapt_i(rise_ev), .tick_o(tick), .running_o(running)
  );

  generate
    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      pd_pkg::level_t delay;
      assign delay = pd_pkg::level_to_delay(levels_i[c*LW +: LW], mode_switch);
      pd_channel u_ch (
        .clk(clk), .rst_n(rst_n), .load_i(rise_ev), .release_i(rise_ev || fail_ev),
        .tick_i(tick), .delay_i(delay), .trig_n_o(trig_n_o[c])
      );
    end
  endgenerate

  assign mains_fail_o = mains_fail;

  // R4: the zero-cross rise releases every trigger
  assert_release_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> (&trig_n_o));
  // R11: no trigger is active while mains has failed
  assert_fail_outputs_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mains_fail |-> (&trig_n_o && !running));
  // R12: a falling edge clears the failure
  assert_fall_clears_fail_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !mains_fail);
  // R2: ticks only occur inside a timed half-cycle
  assert_tick_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (!zc_prev_q && !mains_fail));
endmodule

// File: tb/phase_dimmer_test.sv
module phase_dimmer_test;
  localparam int CH = 4;
  localparam int LW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, zc, sw;
  logic [CH*LW-1:0] lv;
  wire  [CH-1:0] trig_n;
  wire  mains_fail;

  int checks = 0;
  int errors = 0;
  int reload_m = 248;
  int exp_d[CH];

  phase_dimmer #(.CHANNELS(CH), .CLK_DIV(1), .TICK_W(8), .RELOAD_INIT(248),
                 .WD_DIV(4), .WD_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .zc_in(zc), .mode_switch(sw), .levels_i(lv),
    .trig_n_o(trig_n), .mains_fail_o(mains_fail)
  );

  function automatic int ref_delay(input int l, input bit s);
    if (s) return (l >= 128) ? 1 : 254;
    return (l == 255) ? 1 : 255 - l;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic apply(input int nl[CH], input bit ns);
    for (int c = 0; c < CH; c++) lv[c*LW +: LW] = nl[c][LW-1:0];
    sw = ns;
  endtask

  // One zero-cross cycle: L clocks low, H clocks high; new levels applied mid-phase.
  task automatic half(input int L, input int H, input int nl[CH], input bit ns, input bit do_chk);
    int t[CH];
    int n, pos, e, bad;
    n = 256 - reload_m;
    for (int c = 0; c < CH; c++) t[c] = 0;
    @(negedge clk) zc = 1'b0;
    for (int i = 1; i <= L; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == L / 2) apply(nl, ns);
      for (int c = 0; c < CH; c++) if (!trig_n[c] && t[c] == 0) t[c] = i;
      if (i == 10) check(mains_fail == 1'b0, "R12 fail clear", int'(mains_fail), 0);
    end
    zc = 1'b1;
    if (do_chk) begin
      for (int c = 0; c < CH; c++) begin
        e = (3 + exp_d[c] * n <= L) ? 3 + exp_d[c] * n : 0;
        if (e == 0) check(t[c] == 0, "R3 R5 no fire", t[c], 0);
        else check(t[c] >= e - 1 && t[c] <= e + 1, "R3 R2 fire time", t[c], e);
      end
    end
    pos = ((L - 1) / n) % 256;
    if (pos >= 128 && pos <= 254) reload_m++;
    else if (pos < 2) reload_m--;
    for (int c = 0; c < CH; c++) exp_d[c] = ref_delay(nl[c], ns);
    bad = 0;
    for (int i = 1; i <= H; i++) begin
      @(posedge clk); @(negedge clk);
      if (i >= 3 && trig_n != '1) bad = 1;
    end
    check(bad == 0, "R4 release on rise", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nl[CH];
    rst_n = 1'b0; zc = 1'b1; sw = 1'b0;
    nl = '{255, 255, 255, 255};
    apply(nl, 1'b0);
    for (int c = 0; c < CH; c++) exp_d[c] = 1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(trig_n == '1, "R1 reset triggers", int'(trig_n), 15);
    check(mains_fail == 1'b0, "R1 reset fail flag", int'(mains_fail), 0);
    repeat (20) @(negedge clk);

    // warm-up, then linear sweep over levels 156..255 (R6)
    half(804, 200, '{156, 157, 158, 159}, 1'b0, 1'b0);
    for (int g = 1; g < 25; g++) begin
      for (int c = 0; c < CH; c++) nl[c] = 156 + 4 * g + c;
      half(804, 200, nl, 1'b0, 1'b1);
    end
    // switch curve (R7), mode changed mid-phase (R5)
    half(804, 200, '{128, 127, 255, 0}, 1'b1, 1'b1);
    half(804, 200, '{0, 192, 63, 129}, 1'b1, 1'b1);
    half(804, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    // adaptation up (R8) and down (R9)
    half(1604, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    half(1604, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    half(1604, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    half(5, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    half(5, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    // boundaries: 255 ticks and 127 ticks hold (R9), 128 raises (R8)
    half(2044, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    half(1020, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    half(1028, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    half(5, 200, '{215, 215, 215, 0}, 1'b0, 1'b1);
    half(804, 200, '{128, 128, 128, 128}, 1'b1, 1'b1);

    // mains failure (R11), no retune after it (R10), recovery (R12)
    @(negedge clk) zc = 1'b0;
    for (int i = 1; i <= 4300; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 100) check(trig_n == '0, "R3 fired before failure", int'(trig_n), 0);
      if (i == 4000) check(mains_fail == 1'b0, "R11 no early fail", int'(mains_fail), 0);
      if (i == 4200) begin
        check(mains_fail == 1'b1, "R11 fail flag", int'(mains_fail), 1);
        check(trig_n == '1, "R11 triggers off", int'(trig_n), 15);
      end
    end
    zc = 1'b1;
    repeat (200) @(negedge clk);
    check(mains_fail == 1'b1, "R11 fail held", int'(mains_fail), 1);
    check(trig_n == '1, "R11 triggers held off", int'(trig_n), 15);
    for (int c = 0; c < CH; c++) exp_d[c] = 1;
    half(804, 200, '{200, 180, 160, 255}, 1'b0, 1'b1);
    half(804, 200, '{200, 180, 160, 255}, 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule